// File: doc/BRIEF.md
# ADC Command Queue Trigger Controller

This block decides when commands leave a small command FIFO and go to an analog-to-digital converter. Software loads commands into the FIFO and picks a trigger mode. The block then makes one pass through the queued commands and sends each one to one of two targets. The first target is an on-chip command buffer, which takes a word in a single cycle. The second is an external converter, reached through a serial shifter that sends one bit per shift pulse.

Software controls the block with a few inputs. A control write carries the mode, a scan-start bit and a strobe. A separate strobe flushes the FIFO, and the transfer counter can be loaded. The block reports whether the queue is running, how many transfers have completed, how full the FIFO is, and a fill request. Turning the queue off follows rules that depend on the target. An on-chip word that is already leaving is always delivered. A serial message is cut short only while fewer than 26 of its bits have gone out.

The controller has three states:
- `ST_IDLE` waits for a trigger.
- `ST_SCAN` pops the FIFO head and dispatches it.
- `ST_SHIFT` waits for the serial shifter.

It makes these transitions:
- idle→scan on trigger.
- scan→idle on an end-of-queue command or on disable.
- scan→shift when the head is a serial command.
- shift→scan when a message completes.
- shift→idle when a message is aborted, or when it completes with end-of-queue set or with the mode off.

Top module: `adcq_trig_ctrl`

## Requirements
- R1: The mode field uses these codes: 0 off, 1 software single-scan, 2 rising-edge single-scan, 3 falling-edge single-scan. While the mode is not off, a write that selects any mode other than off is ignored.
- R2: A write that moves the mode from off to another value takes effect only while the queue is idle (`q_running`=0). Otherwise the mode stays off.
- R3: If the queue is turned off while no transfer is in progress, `q_running` falls on the same clock edge at which the mode reads off.
- R4: Suppose a disabling write lands in the cycle where an on-chip word is being written (`buf_we`=1). That word is still delivered, the counter increases by one, and the queue goes idle.
- R5: Suppose a serial message has sent fewer than 26 bits when the queue is turned off. The message is aborted and `ser_active` drops. The counter does not change, the queue goes idle, and the aborted command is not restored to the FIFO.
- R6: Suppose a serial message has sent 26 or more bits when the queue is turned off. The message runs to its end and the counter increases by one. Only then does the queue go idle.
- R7: Turning the queue off keeps the FIFO contents and the counter. A flush strobe empties the FIFO in one cycle, but only while the queue is idle. A counter write loads `cnt_wdata`, so writing 0 clears the counter.
- R8: The scan-start bit reads 0 whenever the mode is off. A write sets it only if, after that write, the mode is not off. This includes the same write that leaves off.
- R9: In the edge modes a pass starts only if the start bit is set and a matching edge occurs after the mode has taken effect. A level that was already present at the mode change does not start a pass.
- R10: A command word uses bit 31 as the end-of-queue flag and bit 30 as the target (0 = on-chip buffer, 1 = serial). Dispatching a word with bit 31 set ends the pass, clears the start bit and returns to idle. Later commands stay in the FIFO.
- R11: A serial message is the whole 32-bit command word. It is sent MSB first on `ser_dout`, which advances by one bit per `ser_shift` pulse.
- R12: `fill_req` is high exactly when `fill_en` is 1 and the FIFO is not full, whatever the mode.
- R13: The FIFO holds 4 entries. A push into a full FIFO is dropped, and `fifo_level` reports the number of stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_mode | input | 2 | Requested mode |
| ctl_start | input | 1 | Scan-start bit carried by the control write |
| ctl_flush | input | 1 | FIFO flush strobe |
| fill_en | input | 1 | Fill request enable |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 8 | Counter load value |
| push_en | input | 1 | FIFO push strobe |
| push_data | input | 32 | Command word to push |
| trig_in | input | 1 | External trigger signal |
| ser_shift | input | 1 | Serial shift-enable pulse |
| cur_mode | output | 2 | Current mode |
| scan_armed | output | 1 | Scan-start bit |
| q_running | output | 1 | Queue status (1 = running) |
| xfer_cnt | output | 8 | Completed transfer counter |
| fifo_level | output | 3 | FIFO entry count |
| fill_req | output | 1 | FIFO fill request |
| buf_we | output | 1 | On-chip buffer write strobe |
| buf_data | output | 32 | On-chip buffer write data |
| ser_dout | output | 1 | Serial data out |
| ser_active | output | 1 | Serial message in flight |

## Verification
The disabling control write and the completion of a transfer are the two functions that can meet in one cycle. For the on-chip case, the bench starts a software scan and issues the disabling write in the exact cycle where the first word is being written. It then requires one logged buffer write, a counter one higher, idle status and one entry left in the FIFO. For the serial case, the bench stops shifting after exactly 25 bits and after exactly 26 bits before disabling. It requires an abort in the first case and a full message plus one count in the second. In the second case it also checks that a re-enable write and a flush strobe are both refused while the message finishes.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_SWSCAN = 2'd1,
        MODE_RISE   = 2'd2,
        MODE_FALL   = 2'd3
    } qmode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_SHIFT = 2'd2
    } qstate_e;

endpackage

// File: rtl/adcq_cmd_fifo.sv
module adcq_cmd_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = mem[rp];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push_ok) wp <= nxt(wp);
            if (pop_ok)  rp <= nxt(rp);
            if (push_ok && !pop_ok)      level <= level + 1'b1;
            else if (pop_ok && !push_ok) level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/adcq_edge_det.sv
module adcq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev, vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b0;
            vld  <= 1'b0;
        end else if (clr) begin
            vld  <= 1'b0;
        end else begin
            prev <= sig;
            vld  <= 1'b1;
        end
    end

    assign rise = vld && sig && !prev;
    assign fall = vld && !sig && prev;
endmodule

// File: rtl/adcq_ser_tx.sv
module adcq_ser_tx #(
    parameter int DW  = 32,
    localparam int BW = $clog2(DW) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] data,
    input  logic          shift,
    input  logic          abort,
    output logic          dout,
    output logic          busy,
    output logic          done,
    output logic [BW-1:0] bits
);
    logic [DW-1:0] sh;

    assign done = busy && shift && !abort && (bits == BW'(DW - 1));
    assign dout = busy ? sh[DW-1] : 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            bits <= '0;
            busy <= 1'b0;
        end else if (load) begin
            sh   <= data;
            bits <= '0;
            busy <= 1'b1;
        end else if (abort) begin
            busy <= 1'b0;
        end else if (busy && shift) begin
            sh   <= {sh[DW-2:0], 1'b0};
            bits <= bits + 1'b1;
            if (done) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/adcq_trig_ctrl.sv
module adcq_trig_ctrl
    import adcq_pkg::*;
#(
    parameter int DW          = 32,
    parameter int DEPTH       = 4,
    parameter int CNT_W       = 8,
    parameter int ABORT_LIMIT = 26
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_wr,
    input  logic [1:0]             ctl_mode,
    input  logic                   ctl_start,
    input  logic                   ctl_flush,
    input  logic                   fill_en,
    input  logic                   cnt_wr,
    input  logic [CNT_W-1:0]       cnt_wdata,
    input  logic                   push_en,
    input  logic [DW-1:0]          push_data,
    input  logic                   trig_in,
    input  logic                   ser_shift,
    output logic [1:0]             cur_mode,
    output logic                   scan_armed,
    output logic                   q_running,
    output logic [CNT_W-1:0]       xfer_cnt,
    output logic [$clog2(DEPTH):0] fifo_level,
    output logic                   fill_req,
    output logic                   buf_we,
    output logic [DW-1:0]          buf_data,
    output logic                   ser_dout,
    output logic                   ser_active
);
    localparam int LW      = $clog2(DEPTH) + 1;
    localparam int BW      = $clog2(DW) + 1;
    localparam int EOQ_POS = DW - 1;
    localparam int TGT_POS = DW - 2;

    qmode_e         mode_q, mode_n;
    qstate_e        st_q, st_n;
    logic           wr_ok, dis_now, trig_ok, rise, fall;
    logic           sss_q, sss_n, ser_eoq_q;
    logic [DW-1:0]  head;
    logic           empty, full, pop, flush_ok;
    logic           ser_load, ser_abort, ser_done, ser_busy;
    logic [BW-1:0]  ser_bits;
    logic           xfer_done, eoq_hit, buf_we_c;
    logic [CNT_W-1:0] cnt_q;

    adcq_cmd_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush_ok), .push(push_en),
        .wdata(push_data), .pop(pop), .head(head), .level(fifo_level),
        .full(full), .empty(empty)
    );

    adcq_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .clr(mode_q == MODE_OFF),
        .sig(trig_in), .rise(rise), .fall(fall)
    );

    adcq_ser_tx #(.DW(DW)) u_ser (
        .clk(clk), .rst_n(rst_n), .load(ser_load), .data(head),
        .shift(ser_shift), .abort(ser_abort), .dout(ser_dout),
        .busy(ser_busy), .done(ser_done), .bits(ser_bits)
    );

    // mode write filter and start-bit update
    always_comb begin
        wr_ok = 1'b0;
        if (ctl_wr) begin
            if (mode_q != MODE_OFF) wr_ok = (qmode_e'(ctl_mode) == MODE_OFF);
            else wr_ok = (qmode_e'(ctl_mode) == MODE_OFF) || (st_q == ST_IDLE);
        end
        mode_n   = wr_ok ? qmode_e'(ctl_mode) : mode_q;
        dis_now  = (mode_n == MODE_OFF);
        flush_ok = ctl_flush && (st_q == ST_IDLE);
        trig_ok  = (mode_q == MODE_SWSCAN) ||
                   (mode_q == MODE_RISE && rise) ||
                   (mode_q == MODE_FALL && fall);
    end

    // next state and per-state actions
    always_comb begin
        st_n      = st_q;
        pop       = 1'b0;
        buf_we_c  = 1'b0;
        ser_load  = 1'b0;
        ser_abort = 1'b0;
        xfer_done = 1'b0;
        eoq_hit   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (!dis_now && sss_q && trig_ok) st_n = ST_SCAN;
            end
            ST_SCAN: begin
                if (!empty && !head[TGT_POS]) begin
                    pop       = 1'b1;
                    buf_we_c  = 1'b1;
                    xfer_done = 1'b1;
                    eoq_hit   = head[EOQ_POS];
                    if (head[EOQ_POS] || dis_now) st_n = ST_IDLE;
                end else if (!empty && !dis_now) begin
                    pop      = 1'b1;
                    ser_load = 1'b1;
                    st_n     = ST_SHIFT;
                end else if (dis_now) begin
                    st_n = ST_IDLE;
                end
            end
            ST_SHIFT: begin
                if (dis_now && ser_bits < BW'(ABORT_LIMIT)) begin
                    ser_abort = 1'b1;
                    st_n      = ST_IDLE;
                end else if (ser_done) begin
                    xfer_done = 1'b1;
                    eoq_hit   = ser_eoq_q;
                    st_n      = (ser_eoq_q || dis_now) ? ST_IDLE : ST_SCAN;
                end
            end
            default: st_n = ST_IDLE;
        endcase

        if (dis_now)                sss_n = 1'b0;
        else if (ctl_wr && ctl_start) sss_n = 1'b1;
        else if (eoq_hit)           sss_n = 1'b0;
        else                        sss_n = sss_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_OFF;
            sss_q     <= 1'b0;
            ser_eoq_q <= 1'b0;
            cnt_q     <= '0;
        end else begin
            mode_q <= mode_n;
            sss_q  <= sss_n;
            if (ser_load) ser_eoq_q <= head[EOQ_POS];
            if (cnt_wr)         cnt_q <= cnt_wdata;
            else if (xfer_done) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cur_mode   = mode_q;
    assign scan_armed = sss_q;
    assign q_running  = (st_q != ST_IDLE);
    assign xfer_cnt   = cnt_q;
    assign fill_req   = fill_en && !full;
    assign buf_we     = buf_we_c;
    assign buf_data   = head;
    assign ser_active = ser_busy;

    localparam int UNUSED_LW = LW;
endmodule

// File: rtl/adcq_trig_chk.sv
module adcq_trig_chk #(
    parameter int DEPTH       = 4,
    parameter int CNT_W       = 8,
    parameter int BW          = 6,
    parameter int LW          = 3,
    parameter int ABORT_LIMIT = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cur_mode,
    input logic             q_running,
    input logic             scan_armed,
    input logic             ser_active,
    input logic [BW-1:0]    ser_bits,
    input logic [LW-1:0]    fifo_level,
    input logic             fill_en,
    input logic             fill_req,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] xfer_cnt,
    input logic             buf_we,
    input logic             ser_load
);
    p_mode_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != 2'd0) |=> (cur_mode == 2'd0 || $stable(cur_mode)));

    p_stay_off_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 2'd0 && q_running) |=> (cur_mode == 2'd0));

    p_off_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 2'd0 && !ser_active) |-> !q_running);

    p_late_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_active && cur_mode == 2'd0) |-> (ser_bits >= BW'(ABORT_LIMIT)));

    p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (xfer_cnt == $past(xfer_cnt) ||
                     xfer_cnt == $past(xfer_cnt) + CNT_W'(1)));

    p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 2'd0) |-> !scan_armed);

    p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_we, ser_load}));

    p_fill_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en || fifo_level == LW'(DEPTH)) |-> !fill_req);

    p_level_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(DEPTH));
endmodule

bind adcq_trig_ctrl adcq_trig_chk #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .BW(BW), .LW(LW), .ABORT_LIMIT(ABORT_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .q_running(q_running),
    .scan_armed(scan_armed), .ser_active(ser_active), .ser_bits(ser_bits),
    .fifo_level(fifo_level), .fill_en(fill_en), .fill_req(fill_req),
    .cnt_wr(cnt_wr), .xfer_cnt(xfer_cnt), .buf_we(buf_we), .ser_load(ser_load)
);

// File: tb/tb_adcq_trig_ctrl.sv
module tb_adcq_trig_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, ctl_start = 1'b0, ctl_flush = 1'b0;
    logic [1:0]  ctl_mode = 2'd0;
    logic        fill_en = 1'b0, cnt_wr = 1'b0;
    logic [7:0]  cnt_wdata = '0;
    logic        push_en = 1'b0;
    logic [31:0] push_data = '0;
    logic        trig_in = 1'b0, ser_shift = 1'b0;
    logic [1:0]  cur_mode;
    logic        scan_armed, q_running, fill_req, buf_we, ser_dout, ser_active;
    logic [7:0]  xfer_cnt;
    logic [2:0]  fifo_level;
    logic [31:0] buf_data;

    adcq_trig_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
        .ctl_start(ctl_start), .ctl_flush(ctl_flush), .fill_en(fill_en),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .push_en(push_en),
        .push_data(push_data), .trig_in(trig_in), .ser_shift(ser_shift),
        .cur_mode(cur_mode), .scan_armed(scan_armed), .q_running(q_running),
        .xfer_cnt(xfer_cnt), .fifo_level(fifo_level), .fill_req(fill_req),
        .buf_we(buf_we), .buf_data(buf_data), .ser_dout(ser_dout),
        .ser_active(ser_active)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_bad = 0, buf_n = 0;
    logic [31:0] buf_last = '0;
    bit finished = 0;

    always @(negedge clk) if (rst_n && buf_we) begin
        buf_n++;
        buf_last = buf_data;
    end

    task automatic chk(string tag, longint unsigned act, longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr_ctl(logic [1:0] m, logic s);
        ctl_wr = 1'b1; ctl_mode = m; ctl_start = s;
        step();
        ctl_wr = 1'b0; ctl_start = 1'b0;
    endtask

    task automatic push(logic [31:0] d);
        push_en = 1'b1; push_data = d;
        step();
        push_en = 1'b0;
    endtask

    task automatic flush();
        ctl_flush = 1'b1; step(); ctl_flush = 1'b0;
    endtask

    task automatic shift_bits(int n, output logic [31:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            rx = {rx[30:0], ser_dout};
            ser_shift = 1'b1;
            step();
        end
        ser_shift = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset mode", cur_mode, 0);
        chk("R3 reset idle", q_running, 0);
        chk("R7 reset count", xfer_cnt, 0);
        chk("R13 reset level", fifo_level, 0);
        chk("R8 reset start", scan_armed, 0);
    endtask

    task automatic t_fifo_fill();
        fill_en = 1'b1; step();
        chk("R12 fill req empty", fill_req, 1);
        for (int i = 0; i < 5; i++) push(32'h0000_0100 + i);
        chk("R13 level capped", fifo_level, 4);
        chk("R12 fill req full", fill_req, 0);
        flush();
        chk("R7 flush idle", fifo_level, 0);
        chk("R12 fill req after flush", fill_req, 1);
        fill_en = 1'b0; step();
        chk("R12 fill disabled", fill_req, 0);
    endtask

    task automatic t_mode_lock();
        wr_ctl(2'd0, 1'b1);
        chk("R8 start ignored while off", scan_armed, 0);
        wr_ctl(2'd1, 1'b0);
        chk("R2 enable from idle", cur_mode, 1);
        wr_ctl(2'd2, 1'b0);
        chk("R1 mode change locked", cur_mode, 1);
        wr_ctl(2'd0, 1'b0);
        chk("R1 disable accepted", cur_mode, 0);
    endtask

    task automatic t_disable_empty();
        wr_ctl(2'd1, 1'b1);
        chk("R8 start set with enable", scan_armed, 1);
        step(2);
        chk("R3 running on empty fifo", q_running, 1);
        wr_ctl(2'd0, 1'b0);
        chk("R3 idle with mode off", q_running, 0);
        chk("R3 mode off", cur_mode, 0);
        chk("R8 start cleared by disable", scan_armed, 0);
    endtask

    task automatic t_eoq_pass();
        int b0 = buf_n; int c0 = xfer_cnt;
        push(32'h0000_0A0A); push(32'h8000_0B0B); push(32'h0000_0C0C);
        wr_ctl(2'd1, 1'b1);
        step(5);
        chk("R10 words sent", buf_n - b0, 2);
        chk("R10 last word", buf_last, 32'h8000_0B0B);
        chk("R10 count", xfer_cnt, c0 + 2);
        chk("R10 remainder kept", fifo_level, 1);
        chk("R10 idle after pass", q_running, 0);
        chk("R10 start cleared", scan_armed, 0);
        wr_ctl(2'd0, 1'b0); flush();
    endtask

    task automatic t_onchip_overlap();
        int b0 = buf_n; int c0 = xfer_cnt;
        push(32'h0000_0D0D); push(32'h0000_0E0E);
        wr_ctl(2'd1, 1'b1);
        step();
        chk("R4 write in flight", buf_we, 1);
        wr_ctl(2'd0, 1'b0);
        chk("R4 word delivered", buf_n - b0, 1);
        chk("R4 delivered data", buf_last, 32'h0000_0D0D);
        chk("R4 count bumped", xfer_cnt, c0 + 1);
        chk("R4 idle", q_running, 0);
        chk("R7 fifo kept on disable", fifo_level, 1);
        flush();
    endtask

    task automatic t_serial_full();
        logic [31:0] rx; int c0 = xfer_cnt;
        push(32'h5A3C_96E1); push(32'h8000_0F0F);
        wr_ctl(2'd1, 1'b1);
        step(2);
        chk("R11 serial active", ser_active, 1);
        shift_bits(32, rx);
        chk("R11 serial word", rx, 32'h5A3C_96E1);
        step(2);
        chk("R11 count after pass", xfer_cnt, c0 + 2);
        chk("R10 idle after serial pass", q_running, 0);
        wr_ctl(2'd0, 1'b0);
    endtask

    task automatic t_serial_abort();
        logic [31:0] rx; int c0 = xfer_cnt;
        push(32'h4123_4567);
        wr_ctl(2'd1, 1'b1);
        step(2);
        shift_bits(25, rx);
        wr_ctl(2'd0, 1'b0);
        chk("R5 aborted", ser_active, 0);
        chk("R5 idle", q_running, 0);
        chk("R5 no count", xfer_cnt, c0);
        chk("R5 command dropped", fifo_level, 0);
    endtask

    task automatic t_serial_late();
        logic [31:0] rx; int c0 = xfer_cnt;
        push(32'h7FFF_0001); push(32'h0000_1111);
        wr_ctl(2'd1, 1'b1);
        step(2);
        shift_bits(26, rx);
        flush();
        chk("R7 flush refused while running", fifo_level, 1);
        wr_ctl(2'd0, 1'b0);
        chk("R6 mode off", cur_mode, 0);
        chk("R6 still running", q_running, 1);
        chk("R6 message continues", ser_active, 1);
        wr_ctl(2'd1, 1'b1);
        chk("R2 enable refused while running", cur_mode, 0);
        chk("R8 start refused while off", scan_armed, 0);
        shift_bits(6, rx);
        chk("R6 count bumped", xfer_cnt, c0 + 1);
        chk("R6 idle after finish", q_running, 0);
        chk("R7 fifo kept", fifo_level, 1);
        flush();
        chk("R7 flush when idle", fifo_level, 0);
        cnt_wr = 1'b1; cnt_wdata = 8'd0; step(); cnt_wr = 1'b0;
        chk("R7 counter cleared", xfer_cnt, 0);
    endtask

    task automatic t_edge_rise();
        int c0 = xfer_cnt;
        trig_in = 1'b1;
        push(32'h8000_2222);
        wr_ctl(2'd2, 1'b1);
        step(4);
        chk("R9 held level no start", fifo_level, 1);
        chk("R9 held level idle", q_running, 0);
        trig_in = 1'b0; step();
        trig_in = 1'b1; step(4);
        chk("R9 rise sent", xfer_cnt, c0 + 1);
        chk("R9 rise drained", fifo_level, 0);
        wr_ctl(2'd0, 1'b0);
    endtask

    task automatic t_edge_fall();
        int c0 = xfer_cnt;
        trig_in = 1'b0;
        push(32'h8000_3333);
        wr_ctl(2'd3, 1'b1);
        step(3);
        chk("R9 low level no start", fifo_level, 1);
        trig_in = 1'b1; step(3);
        chk("R9 rise ignored in fall mode", fifo_level, 1);
        trig_in = 1'b0; step(4);
        chk("R9 fall sent", xfer_cnt, c0 + 1);
        wr_ctl(2'd0, 1'b0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_fifo_fill();
        t_mode_lock();
        t_disable_empty();
        t_eoq_pass();
        t_onchip_overlap();
        t_serial_full();
        t_serial_abort();
        t_serial_late();
        t_edge_rise();
        t_edge_fall();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule